// File: doc/BRIEF.md
# Serial Flash Layout Discovery and Address Mapper

This block runs once after a start pulse and learns how a serial flash built from one or two components is laid out. It reads words through a simple request/response memory read port. It first fetches a signature word and checks it against a fixed constant. If the signature matches, it fetches a map word. It then follows the pointer held in the map word to a component record. From that record it decodes the size of the first chip, and from the map word it takes the number of chip selects. These descriptor reads carry no chip context, so they use raw addresses that start at zero.

When discovery ends, a one-cycle completion pulse is given together with a cause code. On success the first-chip size and the chip-select count are latched. A combinational mapper then turns any chip-relative access into a flat linear address. Accesses on chip select 1 are placed directly after the first chip. The wire protocol of the flash is handled elsewhere.

Top module: `flash_layout_discover`

## Requirements
- R1: After reset, rd_req=0, done=0, err=0, err_code=0, num_cs=1 and chip0_size=0.
- R2: The first request goes to byte address 0x10. The request to 0x14 is issued only after the word from 0x10 has returned. Each request is a single-cycle rd_req pulse, and only one request is outstanding at a time.
- R3: If the word read from 0x10 is not 0x0FF0A55A, the run ends with err_code=1 and no further request is issued.
- R4: The third request goes to the map word's bits [7:0] shifted left by 4.
- R5: Bits [3:0] of the component word give the first-chip size. Codes 0 to 7 give 512 KiB shifted left by the code, so chip0_size spans 0x80000 to 0x4000000. This value is latched when the run succeeds.
- R6: A component-word code from 8 to 15 ends the run with err_code=2.
- R7: The map word's bits [9:8] set the chip-select count: 0 gives num_cs=1 and 1 gives num_cs=2. The values 2 and 3 end the run with err_code=3. This check is made only after the size code has been accepted.
- R8: A response with rd_err=1 at any step ends the run with err_code=4, and no further request is issued.
- R9: done is high for exactly one cycle. It rises in the cycle after the final response is accepted. err_code and err (err = err_code nonzero) hold their value until the next start, and the next start clears them.
- R10: map_addr equals map_offset when map_cs=0, and equals chip0_size plus map_offset when map_cs=1.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins discovery when the block is idle |
| rd_req | output | 1 | Single-cycle read request |
| rd_addr | output | 24 | Byte address of the requested word |
| rd_valid | input | 1 | Response strobe |
| rd_data | input | 32 | Response word |
| rd_err | input | 1 | The response is a failed read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last run ended in error |
| err_code | output | 3 | 0 ok, 1 signature, 2 size code, 3 count, 4 read |
| chip0_size | output | 27 | First-chip size in bytes |
| num_cs | output | 2 | Number of chip selects (1 or 2) |
| map_cs | input | 1 | Chip select of the access to map |
| map_offset | input | 24 | Chip-relative offset |
| map_addr | output | 27 | Linear address |

## Verification
A request appears on rd_req one cycle after start. A request also appears one cycle after each accepted response that does not end the run. done, err_code, chip0_size and num_cs all change at the edge that follows the final accepted response. The bench drives every input at falling edges and reads the outputs at the next falling edge, which is exactly one register stage later. map_addr is combinational, so it is read half a cycle after its inputs are driven.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_SIGNATURE = 3'd1,
    ERR_DENSITY   = 3'd2,
    ERR_COUNT     = 3'd3,
    ERR_READ      = 3'd4
  } fld_err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ_SIG, ST_WAIT_SIG, ST_REQ_MAP,
    ST_WAIT_MAP, ST_REQ_COMP, ST_WAIT_COMP, ST_DONE
  } fld_state_e;

  localparam logic [31:0] DESC_SIGNATURE = 32'h0FF0_A55A;
  localparam int unsigned DESC_BASE      = 32'h10;
  localparam int unsigned MAP_KEEP_W     = 10;  // pointer [7:0], count [9:8]
  localparam int unsigned PTR_SHIFT      = 4;
endpackage

// File: rtl/fld_density.sv
module fld_density #(
  parameter int unsigned BASE_LOG2 = 19,
  parameter int unsigned NUM_CODES = 8,
  localparam int unsigned SIZE_W   = BASE_LOG2 + NUM_CODES
) (
  input  logic [3:0]        code,
  output logic              code_ok,
  output logic [SIZE_W-1:0] size
);
  always_comb begin
    code_ok = (32'(code) < NUM_CODES);
    size    = '0;
    if (code_ok) size = SIZE_W'(1) << (BASE_LOG2 + 32'(code));
  end
endmodule

// File: rtl/fld_addr_map.sv
module fld_addr_map #(
  parameter int unsigned OFF_W = 24,
  parameter int unsigned LIN_W = 27
) (
  input  logic             cs,
  input  logic [OFF_W-1:0] offset,
  input  logic [LIN_W-1:0] chip0_base,
  output logic [LIN_W-1:0] lin_addr
);
  always_comb begin
    lin_addr = LIN_W'(offset) + (cs ? chip0_base : '0);
  end
endmodule

// File: rtl/fld_seq.sv
module fld_seq
  import fld_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err,
  input  logic              dens_ok,
  output logic              commit,
  output logic              cs_pair,
  output logic              done,
  output fld_err_e          err_code
);
  fld_state_e             state_q, state_d;
  logic [MAP_KEEP_W-1:0]  map_q, map_d;
  fld_err_e               err_q, err_d;
  logic                   map_en;

  always_comb begin
    state_d = state_q;
    map_d   = rd_data[MAP_KEEP_W-1:0];
    map_en  = 1'b0;
    err_d   = err_q;
    commit  = 1'b0;
    rd_req  = 1'b0;
    rd_addr = '0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_REQ_SIG;
        err_d   = ERR_NONE;
      end
      ST_REQ_SIG: begin
        rd_req  = 1'b1;
        rd_addr = ADDR_W'(DESC_BASE);
        state_d = ST_WAIT_SIG;
      end
      ST_WAIT_SIG: if (rd_valid) begin
        if (rd_err) begin
          err_d = ERR_READ; state_d = ST_DONE;
        end else if (rd_data[31:0] != DESC_SIGNATURE) begin
          err_d = ERR_SIGNATURE; state_d = ST_DONE;
        end else begin
          state_d = ST_REQ_MAP;
        end
      end
      ST_REQ_MAP: begin
        rd_req  = 1'b1;
        rd_addr = ADDR_W'(DESC_BASE + 4);
        state_d = ST_WAIT_MAP;
      end
      ST_WAIT_MAP: if (rd_valid) begin
        if (rd_err) begin
          err_d = ERR_READ; state_d = ST_DONE;
        end else begin
          map_en  = 1'b1;
          state_d = ST_REQ_COMP;
        end
      end
      ST_REQ_COMP: begin
        rd_req  = 1'b1;
        rd_addr = ADDR_W'({map_q[7:0], {PTR_SHIFT{1'b0}}});
        state_d = ST_WAIT_COMP;
      end
      ST_WAIT_COMP: if (rd_valid) begin
        state_d = ST_DONE;
        if (rd_err)              err_d = ERR_READ;
        else if (!dens_ok)       err_d = ERR_DENSITY;
        else if (map_q[9] != 1'b0) err_d = ERR_COUNT;
        else                     commit = 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= ERR_NONE;
      map_q   <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (map_en) map_q <= map_d;
    end
  end

  assign cs_pair  = map_q[8];
  assign done     = (state_q == ST_DONE);
  assign err_code = err_q;
endmodule

// File: rtl/flash_layout_discover.sv
module flash_layout_discover
  import fld_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_LOG2 = 19,
  parameter int unsigned NUM_CODES = 8,
  localparam int unsigned LIN_W    = BASE_LOG2 + NUM_CODES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err,
  output logic              done,
  output logic              err,
  output logic [2:0]        err_code,
  output logic [LIN_W-1:0]  chip0_size,
  output logic [1:0]        num_cs,
  input  logic              map_cs,
  input  logic [ADDR_W-1:0] map_offset,
  output logic [LIN_W-1:0]  map_addr
);
  logic             dens_ok, commit, cs_pair;
  logic [LIN_W-1:0] dens_size;
  logic [LIN_W-1:0] size_q;
  logic [1:0]       ncs_q;
  fld_err_e         code;

  fld_density #(.BASE_LOG2(BASE_LOG2), .NUM_CODES(NUM_CODES)) u_dens (
    .code(rd_data[3:0]), .code_ok(dens_ok), .size(dens_size)
  );

  fld_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err), .dens_ok(dens_ok),
    .commit(commit), .cs_pair(cs_pair), .done(done), .err_code(code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      ncs_q  <= 2'd1;
    end else if (commit) begin
      size_q <= dens_size;
      ncs_q  <= cs_pair ? 2'd2 : 2'd1;
    end
  end

  fld_addr_map #(.OFF_W(ADDR_W), .LIN_W(LIN_W)) u_map (
    .cs(map_cs), .offset(map_offset), .chip0_base(size_q), .lin_addr(map_addr)
  );

  assign chip0_size = size_q;
  assign num_cs     = ncs_q;
  assign err_code   = code;
  assign err        = (code != ERR_NONE);
endmodule

// File: rtl/fld_checker.sv
module fld_checker #(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned BASE_LOG2 = 19,
  parameter int unsigned LIN_W     = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              done,
  input logic [2:0]        err_code,
  input logic [LIN_W-1:0]  chip0_size,
  input logic [1:0]        num_cs,
  input logic              map_cs,
  input logic [ADDR_W-1:0] map_offset,
  input logic [LIN_W-1:0]  map_addr
);
  assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_code <= 3'd4);
  assert_cs_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'd0) |-> (num_cs == 2'd1 || num_cs == 2'd2));
  assert_size_pow2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'd0) |->
      ($countones(chip0_size) == 1 && chip0_size[BASE_LOG2-1:0] == '0));
  assert_map_cs0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !map_cs |-> map_addr == LIN_W'(map_offset));
endmodule

bind flash_layout_discover fld_checker #(
  .ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2), .LIN_W(LIN_W)
) u_fld_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .done(done),
  .err_code(err_code), .chip0_size(chip0_size), .num_cs(num_cs),
  .map_cs(map_cs), .map_offset(map_offset), .map_addr(map_addr)
);

// File: tb/sim_flash_layout_discover.sv
module sim_flash_layout_discover;
  logic        clk, rst_n, start, rd_valid, rd_err, map_cs;
  logic        rd_req, done, err;
  logic [23:0] rd_addr, map_offset;
  logic [31:0] rd_data;
  logic [2:0]  err_code;
  logic [26:0] chip0_size, map_addr;
  logic [1:0]  num_cs;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [31:0] w_sig, w_map, w_comp;
  int          err_step;
  int          nreq;
  logic [23:0] req_addr [0:7];

  flash_layout_discover u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err), .done(done),
    .err(err), .err_code(err_code), .chip0_size(chip0_size), .num_cs(num_cs),
    .map_cs(map_cs), .map_offset(map_offset), .map_addr(map_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Starts a run and answers requests; returns when done is seen.
  task automatic run(output bit got_done);
    got_done = 0;
    nreq = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin got_done = 1; break; end
      if (rd_req) begin
        if (nreq < 8) req_addr[nreq] = rd_addr;
        @(negedge clk);
        rd_valid = 1'b1;
        rd_err   = (nreq == err_step);
        rd_data  = (nreq == 0) ? w_sig : (nreq == 1) ? w_map : w_comp;
        nreq++;
        @(negedge clk);
        rd_valid = 1'b0; rd_err = 1'b0; rd_data = '0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic expect_done(input bit got, input string tag);
    check(got, {tag, " done pulse"}, 32'(got), 1);
    @(negedge clk);
    check(!done, {tag, " done one cycle"}, 32'(done), 0);
  endtask

  task automatic t_reset;
    check(rd_req == 0 && done == 0 && err == 0, "R1 idle outputs",
          {29'd0, rd_req, done, err}, 0);
    check(err_code == 0, "R1 err_code", 32'(err_code), 0);
    check(num_cs == 1, "R1 num_cs", 32'(num_cs), 1);
    check(chip0_size == 0, "R1 chip0_size", 32'(chip0_size), 0);
  endtask

  task automatic t_good_two_chips;
    bit got;
    w_sig = 32'h0FF0A55A; w_map = 32'h0000_0103; w_comp = 32'h0000_0003; err_step = -1;
    run(got);
    check(nreq == 3, "R2 request count", 32'(nreq), 3);
    check(req_addr[0] == 24'h10, "R2 first addr", 32'(req_addr[0]), 32'h10);
    check(req_addr[1] == 24'h14, "R2 second addr", 32'(req_addr[1]), 32'h14);
    check(req_addr[2] == 24'h30, "R4 pointer addr", 32'(req_addr[2]), 32'h30);
    check(err_code == 0 && err == 0, "R9 ok code", 32'(err_code), 0);
    check(chip0_size == 27'h400000, "R5 size code3", 32'(chip0_size), 32'h400000);
    check(num_cs == 2, "R7 two chips", 32'(num_cs), 2);
    expect_done(got, "R9");
    map_cs = 1'b1; map_offset = 24'h000123; #1;
    check(map_addr == 27'h400123, "R10 cs1 map", 32'(map_addr), 32'h400123);
    map_cs = 1'b0; #1;
    check(map_addr == 27'h000123, "R10 cs0 map", 32'(map_addr), 32'h123);
    map_cs = 1'b1; map_offset = 24'hFFFFFF; #1;
    check(map_addr == 27'h13FFFFF, "R10 cs1 top", 32'(map_addr), 32'h13FFFFF);
  endtask

  task automatic t_all_densities;
    bit got;
    for (int c = 0; c < 8; c++) begin
      w_sig = 32'h0FF0A55A; w_map = 32'h0000_00A1; w_comp = 32'hFFFF_FFF0 | 32'(c);
      err_step = -1;
      run(got);
      check(req_addr[2] == 24'hA10, "R4 pointer A1", 32'(req_addr[2]), 32'hA10);
      check(err_code == 0, "R5 code ok", 32'(err_code), 0);
      check(chip0_size == (27'h80000 << c), "R5 size", 32'(chip0_size),
            32'(27'h80000 << c));
      check(num_cs == 1, "R7 one chip", 32'(num_cs), 1);
      expect_done(got, "R9");
    end
  endtask

  task automatic t_bad_sig;
    bit got;
    w_sig = 32'h0FF0A55B; w_map = 32'h0000_0001; w_comp = 0; err_step = -1;
    run(got);
    check(err_code == 1 && err == 1, "R3 sig code", 32'(err_code), 1);
    check(nreq == 1, "R3 no more reads", 32'(nreq), 1);
    expect_done(got, "R9");
    repeat (5) @(negedge clk);
    check(err_code == 1 && !rd_req, "R9 code held", 32'(err_code), 1);
    check(num_cs == 1 && chip0_size == 27'h4000000, "R3 config kept",
          32'(chip0_size), 32'h4000000);
  endtask

  task automatic t_bad_density;
    bit got;
    w_sig = 32'h0FF0A55A; w_map = 32'h0000_0002; w_comp = 32'h8; err_step = -1;
    run(got);
    check(err_code == 2, "R6 code 8", 32'(err_code), 2);
    check(nreq == 3, "R6 reads", 32'(nreq), 3);
    expect_done(got, "R6");
    w_map = 32'h0000_0302; w_comp = 32'hF;
    run(got);
    check(err_code == 2, "R6 code 15 before count", 32'(err_code), 2);
    expect_done(got, "R6");
  endtask

  task automatic t_bad_count;
    bit got;
    w_sig = 32'h0FF0A55A; w_comp = 32'h2; err_step = -1;
    w_map = 32'h0000_0205;
    run(got);
    check(err_code == 3, "R7 count 2", 32'(err_code), 3);
    expect_done(got, "R7");
    w_map = 32'h0000_0305;
    run(got);
    check(err_code == 3, "R7 count 3", 32'(err_code), 3);
    check(req_addr[2] == 24'h50, "R4 pointer 05", 32'(req_addr[2]), 32'h50);
    expect_done(got, "R7");
  endtask

  task automatic t_read_err;
    bit got;
    w_sig = 32'h0FF0A55A; w_map = 32'h0000_0001; w_comp = 32'h1;
    for (int s = 0; s < 3; s++) begin
      err_step = s;
      run(got);
      check(err_code == 4 && err, "R8 read error code", 32'(err_code), 4);
      check(nreq == s + 1, "R8 no more reads", 32'(nreq), 32'(s + 1));
      expect_done(got, "R8");
    end
    err_step = -1; w_map = 32'h0000_0001; w_comp = 32'h0;
    run(got);
    check(err_code == 0 && !err, "R9 start clears code", 32'(err_code), 0);
    check(chip0_size == 27'h80000, "R5 size code0", 32'(chip0_size), 32'h80000);
    expect_done(got, "R9");
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_valid = 1'b0; rd_err = 1'b0; rd_data = '0;
    map_cs = 1'b0; map_offset = '0; err_step = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_two_chips();
    t_all_densities();
    t_bad_sig();
    t_bad_density();
    t_bad_count();
    t_read_err();
    summary();
  end
endmodule